// File: doc/BRIEF.md
# Store Buffer with Selectable Write Ordering

This block sits between one processing unit and a shared memory port. It takes the stores that the core has committed and holds them in a small queue, so the core does not wait for the memory write to finish. Loads from the core go past the queued stores. When a load targets an address that still has a queued store, the block answers the load from the queue instead of from memory. When there is no such store, the load goes out on the memory read port.

A mode input controls how queued stores are written to memory. In the strict mode (0), stores are written oldest first, one after the other. In the relaxed mode (1), a younger store may be written ahead of an older one when the two have different addresses. Two stores to the same address are always written in program order. The relaxed drain picks the oldest store that has no older queued store to the same address. While a memory write is stalled, that pick moves on to the next eligible entry. A fence input holds back new loads until the queue is empty, and a done flag reports that the queue has emptied.

Top module: `store_buffer_ord`

## Requirements
- R1: With the fence low, a load is accepted whenever no earlier load is still in progress (`ld_ready` high), even while older stores are still queued.
- R2: A load whose address matches a queued store returns the data of the youngest matching store, without using the memory read port. A store accepted in the same cycle as the load counts as older than the load. The response appears on the cycle after the load is accepted.
- R3: The block offers a memory write whenever the queue is not empty. Each write carries the oldest queued store for its address, so stores to the same address reach memory in program order in both modes.
- R4: In mode 0 (strict ordering), each memory write carries the oldest queued store.
- R5: In mode 1 (relaxed ordering), the drain picks the oldest entry that has no older entry to the same address. When a write is not accepted, it moves priority past the stalled entry, so a younger store to a different address can reach memory before an older one.
- R6: A store becomes visible to other agents only through its memory write handshake. A load that misses the queue returns the value that memory holds at the time of its read request.
- R7: The queue holds 8 stores. When it is full, `st_ready` is low.
- R8: While `fence` is high and stores are queued, `ld_ready` is low. `fence_done` equals `fence` AND (queue empty).
- R9: A load that misses the queue raises `mr_valid` on the cycle after it is accepted and holds it until `mr_ready` is high. The load response follows one cycle after `mr_rsp_valid`. Only one load is in progress at a time, so responses come back in order. While the read is outstanding, `st_ready` is low.
- R10: The ordering mode takes the value of `mode_sel` only on cycles when the queue is empty. A change made while stores are pending takes effect after the queue drains.
- R11: After reset, the queue is empty, `st_ready` and `ld_ready` are high, and `mw_valid`, `mr_valid` and `ld_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Ordering mode request: 0 strict, 1 relaxed |
| fence | input | 1 | Blocks loads until the queue is empty |
| fence_done | output | 1 | Fence high and queue empty |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Store accepted when high with `st_valid` |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core load request |
| ld_ready | output | 1 | Load accepted when high with `ld_valid` |
| ld_addr | input | AW | Load address |
| ld_rsp_valid | output | 1 | One-cycle load response |
| ld_rsp_data | output | DW | Load response data |
| mw_valid | output | 1 | Memory write offered |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |
| mr_valid | output | 1 | Memory read request |
| mr_ready | input | 1 | Memory read request accepted |
| mr_addr | output | AW | Memory read address |
| mr_rsp_valid | input | 1 | Memory read data valid |
| mr_rsp_data | input | DW | Memory read data |

## Verification
The bench builds the block with its default parameters: 8 entries, 16-bit addresses and 32-bit data. Stores use only four addresses and loads use six. This keeps several same-address entries in the queue at once, so youngest-match forwarding and the same-address drain rule are exercised often. Loads still miss to memory regularly. Long windows with `mw_ready` held low fill the queue to 8 entries, which exercises back-pressure and also gives the relaxed drain enough stalled entries to rotate past. A mode request made while stores are pending, and fence windows in both modes, show whether the mode changes too early.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {ORD_TSO = 1'b0, ORD_PSO = 1'b1} order_e;
  typedef enum logic [1:0] {LD_IDLE, LD_MREQ, LD_MWAIT, LD_RESP} ld_state_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  input  logic [IW-1:0]            pop_idx,
  output logic [CW-1:0]            cnt,
  output logic [DEPTH-1:0]         ent_vld,
  output logic [DEPTH-1:0][AW-1:0] ent_addr,
  output logic [DEPTH-1:0][DW-1:0] ent_data
);
  // Entries are kept compacted, index 0 oldest: program order equals index order.
  logic [DEPTH-1:0][AW-1:0] addr_d;
  logic [DEPTH-1:0][DW-1:0] data_d;
  logic [CW-1:0]            cnt_d;
  logic                     upd_en;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = (pop && (i >= int'(pop_idx))) ? i + 1 : i;
      if (src < DEPTH) begin
        addr_d[i] = ent_addr[IW'(src)];
        data_d[i] = ent_data[IW'(src)];
      end else begin
        addr_d[i] = '0;
        data_d[i] = '0;
      end
    end
    cnt_d = cnt - CW'(pop);
    if (push) begin
      addr_d[IW'(cnt_d)] = push_addr;
      data_d[IW'(cnt_d)] = push_data;
      cnt_d              = cnt_d + 1'b1;
    end
  end

  assign upd_en = push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ent_addr <= '0;
      ent_data <= '0;
    end else if (upd_en) begin
      cnt      <= cnt_d;
      ent_addr <= addr_d;
      ent_data <= data_d;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_vld[i] = CW'(i) < cnt;
    end
  end
endmodule

// File: rtl/sb_drain_sel.sv
module sb_drain_sel #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                     pso,
  input  logic [IW-1:0]            rot,
  input  logic [DEPTH-1:0]         ent_vld,
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  output logic                     sel_valid,
  output logic [IW-1:0]            sel_idx
);
  logic [DEPTH-1:0] elig;
  logic             hi_found, lo_found;
  logic [IW-1:0]    hi_idx, lo_idx;

  // An entry may drain when no older entry shares its address.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (ent_vld[j] && (ent_addr[j] == ent_addr[i])) blocked = 1'b1;
      end
      elig[i] = ent_vld[i] && !blocked && (pso || (i == 0));
    end
  end

  // Oldest eligible at or above the rotation point, else oldest overall.
  always_comb begin
    hi_found = 1'b0;
    lo_found = 1'b0;
    hi_idx   = '0;
    lo_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        lo_found = 1'b1;
        lo_idx   = IW'(i);
        if (IW'(i) >= rot) begin
          hi_found = 1'b1;
          hi_idx   = IW'(i);
        end
      end
    end
    sel_valid = lo_found;
    sel_idx   = hi_found ? hi_idx : lo_idx;
  end
endmodule

// File: rtl/sb_load_unit.sv
module sb_load_unit
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     allow,
  input  logic                     ld_valid,
  input  logic [AW-1:0]            ld_addr,
  output logic                     ld_ready,
  output logic                     ld_rsp_valid,
  output logic [DW-1:0]            ld_rsp_data,
  input  logic [DEPTH-1:0]         ent_vld,
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic                     st_fire,
  input  logic [AW-1:0]            st_addr,
  input  logic [DW-1:0]            st_data,
  output logic                     mr_valid,
  input  logic                     mr_ready,
  output logic [AW-1:0]            mr_addr,
  input  logic                     mr_rsp_valid,
  input  logic [DW-1:0]            mr_rsp_data,
  output logic                     mem_busy
);
  ld_state_e     state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          hit;
  logic [DW-1:0] fwd_data;
  logic          ld_fire;

  // Youngest match wins: later indices overwrite, the incoming store last.
  always_comb begin
    hit      = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && (ent_addr[i] == ld_addr)) begin
        hit      = 1'b1;
        fwd_data = ent_data[i];
      end
    end
    if (st_fire && (st_addr == ld_addr)) begin
      hit      = 1'b1;
      fwd_data = st_data;
    end
  end

  assign ld_ready = (state_q == LD_IDLE) && allow;
  assign ld_fire  = ld_valid && ld_ready;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    data_d  = data_q;
    case (state_q)
      LD_IDLE: if (ld_fire) begin
        if (hit) begin
          state_d = LD_RESP;
          data_d  = fwd_data;
        end else begin
          state_d = LD_MREQ;
          addr_d  = ld_addr;
        end
      end
      LD_MREQ:  if (mr_ready) state_d = LD_MWAIT;
      LD_MWAIT: if (mr_rsp_valid) begin
        state_d = LD_RESP;
        data_d  = mr_rsp_data;
      end
      default:  state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign mr_valid     = (state_q == LD_MREQ);
  assign mr_addr      = addr_q;
  assign ld_rsp_valid = (state_q == LD_RESP);
  assign ld_rsp_data  = data_q;
  assign mem_busy     = (state_q == LD_MREQ) || (state_q == LD_MWAIT);
endmodule

// File: rtl/store_buffer_ord.sv
module store_buffer_ord
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          fence,
  output logic          fence_done,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_rsp_valid,
  output logic [DW-1:0] ld_rsp_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic          mr_valid,
  input  logic          mr_ready,
  output logic [AW-1:0] mr_addr,
  input  logic          mr_rsp_valid,
  input  logic [DW-1:0] mr_rsp_data
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [CW-1:0]            cnt;
  logic [DEPTH-1:0]         ent_vld;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [IW-1:0]            sel_idx;
  logic                     sel_valid;
  logic                     st_fire, mw_fire, mem_busy, empty;
  order_e                   mode_q, mode_d;
  logic [IW-1:0]            rot_q, rot_d;

  assign empty      = (cnt == '0);
  assign st_ready   = (cnt < CW'(DEPTH)) && !mem_busy;
  assign st_fire    = st_valid && st_ready;
  assign mw_valid   = sel_valid;
  assign mw_addr    = ent_addr[sel_idx];
  assign mw_data    = ent_data[sel_idx];
  assign mw_fire    = mw_valid && mw_ready;
  assign fence_done = fence && empty;

  sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_fire),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (mw_fire),
    .pop_idx   (sel_idx),
    .cnt       (cnt),
    .ent_vld   (ent_vld),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data)
  );

  sb_drain_sel #(.DEPTH(DEPTH), .AW(AW)) u_sel (
    .pso       (mode_q == ORD_PSO),
    .rot       (rot_q),
    .ent_vld   (ent_vld),
    .ent_addr  (ent_addr),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx)
  );

  sb_load_unit #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_load (
    .clk          (clk),
    .rst_n        (rst_n),
    .allow        (!(fence && !empty)),
    .ld_valid     (ld_valid),
    .ld_addr      (ld_addr),
    .ld_ready     (ld_ready),
    .ld_rsp_valid (ld_rsp_valid),
    .ld_rsp_data  (ld_rsp_data),
    .ent_vld      (ent_vld),
    .ent_addr     (ent_addr),
    .ent_data     (ent_data),
    .st_fire      (st_fire),
    .st_addr      (st_addr),
    .st_data      (st_data),
    .mr_valid     (mr_valid),
    .mr_ready     (mr_ready),
    .mr_addr      (mr_addr),
    .mr_rsp_valid (mr_rsp_valid),
    .mr_rsp_data  (mr_rsp_data),
    .mem_busy     (mem_busy)
  );

  // Mode follows the request only while nothing is queued; rotation only in relaxed mode.
  always_comb begin
    mode_d = empty ? order_e'(mode_sel) : mode_q;
    rot_d  = rot_q;
    if (mode_q != ORD_PSO || mw_fire) begin
      rot_d = '0;
    end else if (mw_valid) begin
      rot_d = (sel_idx == IW'(DEPTH - 1)) ? '0 : sel_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ORD_TSO;
      rot_q  <= '0;
    end else begin
      mode_q <= mode_d;
      rot_q  <= rot_d;
    end
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fence,
  input logic                     fence_done,
  input logic                     st_ready,
  input logic                     ld_ready,
  input logic                     mw_valid,
  input logic [AW-1:0]            mw_addr,
  input logic [DW-1:0]            mw_data,
  input logic                     mr_valid,
  input logic [CW-1:0]            cnt,
  input logic                     mode_q,
  input logic [DEPTH-1:0]         ent_vld,
  input logic [DEPTH-1:0][AW-1:0] ent_addr,
  input logic [DEPTH-1:0][DW-1:0] ent_data,
  input logic [IW-1:0]            sel_idx
);
  function automatic logic older_same(input logic [IW-1:0] idx);
    logic r;
    r = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if ((IW'(j) < idx) && ent_vld[j] && (ent_addr[j] == mw_addr)) r = 1'b1;
    end
    return r;
  endfunction

  AST_FULL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !st_ready); // R7
  AST_STRICT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mode_q) |-> (mw_addr == ent_addr[0] && mw_data == ent_data[0])); // R4
  AST_SAME_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> !older_same(sel_idx)); // R3
  AST_DRAIN_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> mw_valid); // R3
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(mode_q)); // R10
  AST_FENCE_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fence && cnt != '0) |-> !ld_ready); // R8
  AST_FENCE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> (fence && cnt == '0)); // R8
  AST_READ_HOLDS_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    mr_valid |-> !st_ready); // R9
endmodule

bind store_buffer_ord sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fence      (fence),
  .fence_done (fence_done),
  .st_ready   (st_ready),
  .ld_ready   (ld_ready),
  .mw_valid   (mw_valid),
  .mw_addr    (mw_addr),
  .mw_data    (mw_data),
  .mr_valid   (mr_valid),
  .cnt        (cnt),
  .mode_q     (mode_q),
  .ent_vld    (ent_vld),
  .ent_addr   (ent_addr),
  .ent_data   (ent_data),
  .sel_idx    (sel_idx)
);

// File: tb/tb_store_buffer_ord.sv
module tb_store_buffer_ord;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int NCYC  = 9700;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_sel, fence, fence_done;
  logic st_valid, st_ready, ld_valid, ld_ready, ld_rsp_valid;
  logic [AW-1:0] st_addr, ld_addr, mw_addr, mr_addr;
  logic [DW-1:0] st_data, ld_rsp_data, mw_data, mr_rsp_data;
  logic mw_valid, mw_ready, mr_valid, mr_ready, mr_rsp_valid;

  always #4 clk = ~clk;

  store_buffer_ord #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .fence(fence), .fence_done(fence_done),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_rsp_valid(ld_rsp_valid), .ld_rsp_data(ld_rsp_data),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr),
    .mr_rsp_valid(mr_rsp_valid), .mr_rsp_data(mr_rsp_data)
  );

  typedef struct {logic [AW-1:0] a; logic [DW-1:0] d;} st_t;
  st_t           q[$];
  logic [DW-1:0] mem[logic [AW-1:0]];
  int            n_checks = 0, n_fail = 0, reorders = 0;
  bit            done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mrd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=0 expected=1");
    finish_run();
  end

  // Reference state
  int            lst = 0;          // 0 idle, 1 read request, 2 read wait, 3 respond
  logic [AW-1:0] ld_a;
  logic [DW-1:0] exp_ld;
  bit            exp_hit;
  bit            mode_eff = 0;
  bit            rsp_next = 0;
  logic [DW-1:0] rsp_data_next;
  bit            st_f, ld_f, mw_f, mr_f;
  logic [DW-1:0] seq = 32'h100;

  initial begin
    rst_n = 0; mode_sel = 0; fence = 0;
    st_valid = 0; st_addr = '0; st_data = '0;
    ld_valid = 0; ld_addr = '0;
    mw_ready = 0; mr_ready = 0; mr_rsp_valid = 0; mr_rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(st_ready == 1, "R11", "st_ready", st_ready, 1);
    chk(ld_ready == 1, "R11", "ld_ready", ld_ready, 1);
    chk(mw_valid == 0, "R11", "mw_valid", mw_valid, 0);
    chk(mr_valid == 0, "R11", "mr_valid", mr_valid, 0);
    chk(ld_rsp_valid == 0, "R11", "ld_rsp_valid", ld_rsp_valid, 0);
    st_f = 0; ld_f = 0;
    for (int cyc = 0; cyc < NCYC + 600; cyc++) begin
      int pst, pld, pmw;
      bit quiet;
      @(posedge clk);
      #1;
      rst_n = 1;
      quiet = (cyc >= NCYC);
      // phase schedule
      pld = 30;
      pst = 40;
      pmw = ((cyc % 200) < 40) ? 0 : 50;
      if (cyc < 3000)      begin mode_sel = 0; fence = 0; end
      else if (cyc < 3200) begin fence = 1; pst = 0; pld = 50; end
      else if (cyc < 3400) begin fence = 0; mode_sel = 1; pst = 60; pmw = (cyc < 3260) ? 0 : 40; end
      else if (cyc < 3500) begin pst = 0; pmw = 60; end
      else if (cyc < 6500) begin mode_sel = 1; pmw = ((cyc % 200) < 40) ? 0 : 30; end
      else if (cyc < 6700) begin fence = 1; mode_sel = 0; pst = 0; pmw = 60; end
      else                 begin fence = 0; end
      if (quiet) begin pst = 0; pld = 0; pmw = 70; fence = 0; end
      mr_rsp_valid = rsp_next;
      mr_rsp_data  = rsp_next ? rsp_data_next : '0;
      rsp_next     = 0;
      if (!(st_valid && !st_f)) begin
        st_valid = ($urandom_range(0, 99) < pst);
        st_addr  = AW'($urandom_range(0, 3));
        seq      = seq + 1;
        st_data  = seq;
      end
      if (!(ld_valid && !ld_f)) begin
        ld_valid = ($urandom_range(0, 99) < pld);
        ld_addr  = AW'($urandom_range(0, 5));
      end
      mw_ready = ($urandom_range(0, 99) < pmw);
      mr_ready = ($urandom_range(0, 1) == 1);

      @(negedge clk);
      st_f = st_valid && st_ready;
      ld_f = ld_valid && ld_ready;
      mw_f = mw_valid && mw_ready;
      mr_f = mr_valid && mr_ready;

      if (q.size() == DEPTH)
        chk(st_ready == 0, "R7", "st_ready when full", st_ready, 0);
      else if (lst == 1 || lst == 2)
        chk(st_ready == 0, "R9", "st_ready during read", st_ready, 0);
      else
        chk(st_ready == 1, "R7", "st_ready with room", st_ready, 1);
      if (fence && q.size() != 0)
        chk(ld_ready == 0, "R8", "ld_ready under fence", ld_ready, 0);
      else
        chk(ld_ready == (lst == 0), "R1", "ld_ready", ld_ready, (lst == 0));
      chk(fence_done == (fence && q.size() == 0), "R8", "fence_done", fence_done,
          (fence && q.size() == 0));
      chk(mw_valid == (q.size() != 0), "R3", "mw_valid", mw_valid, (q.size() != 0));
      chk(mr_valid == (lst == 1), "R9", "mr_valid", mr_valid, (lst == 1));
      chk(ld_rsp_valid == (lst == 3), "R9", "ld_rsp_valid", ld_rsp_valid, (lst == 3));

      case (lst)
        1: begin
          chk(mr_addr == ld_a, "R9", "mr_addr", mr_addr, ld_a);
          if (mr_f) begin
            rsp_next      = 1;
            rsp_data_next = mrd(ld_a);
            exp_ld        = mrd(ld_a);
            lst           = 2;
          end
        end
        2: if (mr_rsp_valid) lst = 3;
        3: begin
          if (exp_hit) chk(ld_rsp_data == exp_ld, "R2", "forwarded data", ld_rsp_data, exp_ld);
          else         chk(ld_rsp_data == exp_ld, "R6", "memory data", ld_rsp_data, exp_ld);
          lst = 0;
        end
        default: ;
      endcase

      if (ld_f) begin
        exp_hit = 0;
        for (int k = 0; k < q.size(); k++) begin
          if (q[k].a == ld_addr) begin exp_hit = 1; exp_ld = q[k].d; end
        end
        if (st_f && st_addr == ld_addr) begin exp_hit = 1; exp_ld = st_data; end
        ld_a = ld_addr;
        lst  = exp_hit ? 3 : 1;
      end

      if (mw_f) begin
        int idx;
        idx = -1;
        for (int k = q.size() - 1; k >= 0; k--) if (q[k].a == mw_addr) idx = k;
        if (idx < 0) begin
          chk(0, "R3", "write to unknown address", mw_addr, 0);
        end else begin
          chk(q[idx].d == mw_data, "R3", "same-address order data", mw_data, q[idx].d);
          if (!mode_eff) chk(idx == 0, "R4", "strict drain position", idx, 0);
          if (idx > 0) reorders++;
          mem[mw_addr] = mw_data;
          q.delete(idx);
        end
      end

      if (q.size() == 0 && !mw_f) mode_eff = mode_sel;
      else if (q.size() == 0) mode_eff = mode_sel;
      if (st_f) q.push_back('{a: st_addr, d: st_data});
    end
    // R5: relaxed mode must have let some store overtake an older one
    chk(reorders > 0, "R5", "relaxed reorders seen", reorders, 1);
    // R10 / R3: everything drained by the end
    chk(q.size() == 0, "R3", "queue drained at end", q.size(), 0);
    finish_run();
  end
endmodule